// File: doc/BRIEF.md
# Idle Power Restore Delay Sequencer

This block drives the power-enable pin of an external memory device as a processor subsystem goes into idle and comes back out. One control register holds two fields. A keep-power bit decides whether the pin drops low while the subsystem sits idle. A five-bit delay sets how many reference-clock ticks must pass, after the pin is high again on wake, before the block asks for the clocks to restart. The reference clock is an in-domain single-cycle enable, `ref_tick`.

A four-state Moore machine sequences the pin:

- **RUN**: the pin is high. `idle_req` moves the machine to **IDLE**.
- **IDLE**: the pin follows the keep-power bit. `wake_req` moves the machine to **WAKE_DELAY** and loads the delay counter. If both requests are high in IDLE, the wake wins.
- **WAKE_DELAY**: the pin is high. The counter counts reference ticks down to zero, and then the machine moves to **RESTART**.
- **RESTART**: the machine raises `clk_restart` for exactly one cycle and then returns to RUN.

The delay always runs, even when the pin was never lowered. Requests that arrive in a state that does not consume them are dropped.

Top module: `idle_pwr_seq`

## Requirements
- R1: After reset, register address 0 reads 0x0000003F: keep-power bit 5 is 1 and delay bits 4:0 are 31. The machine is in RUN, `ext_pwr_on` is 1 and `clk_restart` is 0.
- R2: A write with `reg_wr`=1 to address 0 sets the keep-power bit from wdata bit 5 and the delay from wdata bits 4:0, at the clock edge. Writes to any other address change nothing.
- R3: On address 0, read bits 31:6 are always 0, whatever was written to them. Every other address reads 0.
- R4: `idle_req` sampled in RUN moves the machine to IDLE at that edge. With keep-power at 0, `ext_pwr_on` is 0 for as long as the machine is in IDLE.
- R5: With keep-power at 1, `ext_pwr_on` stays 1 throughout IDLE.
- R6: `wake_req` sampled in IDLE moves the machine to WAKE_DELAY. `ext_pwr_on` is 1 from the next cycle on, and the counter is loaded with the delay value held at that edge.
- R7: In WAKE_DELAY, each `ref_tick` decrements a nonzero count. The count is sampled each cycle, and the cycle in which it is 0 leads to RESTART at the next edge. With ticks every cycle, the strobe therefore appears delay+2 cycles after the wake edge. A delay of 0 gives the strobe in the cycle after the pin rises.
- R8: The wake delay runs the same way when keep-power is 1 and the pin never fell.
- R9: `clk_restart` is high for exactly one cycle (state RESTART), and the machine then returns to RUN.
- R10: `idle_req` in WAKE_DELAY or RESTART is ignored until RUN is reached. `wake_req` outside IDLE is ignored.
- R11: A delay write during WAKE_DELAY does not change the count already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (control register at 0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ref_tick | input | 1 | One-cycle reference-clock tick |
| idle_req | input | 1 | Request to enter idle |
| wake_req | input | 1 | Request to leave idle |
| ext_pwr_on | output | 1 | Power-enable pin of the external memory |
| clk_restart | output | 1 | One-cycle clock-restart strobe |

## Verification
A wrong internal state shows at the pin or at the strobe within one cycle of when it happens.

- A machine stuck in IDLE holds the pin low, or never produces a strobe.
- A machine that leaves WAKE_DELAY early or late moves the strobe by whole cycles, so the cycle count from the wake edge to the strobe exposes any off-by-one in the counter.
- A counter reloaded at the wrong time, or an idle request accepted mid-wake, changes the pin or the strobe timing in the following cycles.

A cycle-accurate model compares the pin, the strobe and the read data on every clock.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_IDLE    = 2'd1,
        ST_WAKE    = 2'd2,
        ST_RESTART = 2'd3
    } pwr_state_e;

    localparam int unsigned PWR_DLY_W_DEF = 5;

endpackage

// File: rtl/idle_pwr_regs.sv
module idle_pwr_regs #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DLY_W     = 5,
    parameter int unsigned CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              keep_pwr,
    output logic [DLY_W-1:0]  dly
);
    localparam int unsigned KEEP_BIT = DLY_W;
    localparam int unsigned FIELD_W  = DLY_W + 1;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic hit;
    assign hit = (addr == CTRL_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            keep_pwr <= 1'b1;
            dly      <= '1;
        end else if (wr && hit) begin
            keep_pwr <= wdata[KEEP_BIT];
            dly      <= wdata[DLY_W-1:0];
        end
    end

    // Reserved bits and unmapped addresses read as zero
    generate
        if (DATA_W > FIELD_W) begin : g_rsvd
            always_comb begin
                rdata = '0;
                if (hit) rdata[FIELD_W-1:0] = {keep_pwr, dly};
            end
        end else begin : g_full
            always_comb begin
                rdata = '0;
                if (hit) rdata = DATA_W'({keep_pwr, dly});
            end
        end
    endgenerate

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && hit) |=> ($stable(keep_pwr) && $stable(dly))); // R2

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && hit) |=> (dly == $past(wdata[DLY_W-1:0]))); // R2

endmodule

// File: rtl/idle_pwr_delay.sv
module idle_pwr_delay #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             count_en,
    input  logic             tick,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;
    logic             step;

    assign step = count_en && tick && (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (step) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val))); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && count_en && tick && !zero) |=> (cnt == $past(cnt) - 1'b1)); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt)); // R11

endmodule

// File: rtl/idle_pwr_fsm.sv
module idle_pwr_fsm
    import idle_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle_req,
    input  logic wake_req,
    input  logic keep_pwr,
    input  logic cnt_zero,
    output logic cnt_load,
    output logic cnt_en,
    output logic pin,
    output logic restart
);
    pwr_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (idle_req) state_d = ST_IDLE;
            ST_IDLE:    if (wake_req) state_d = ST_WAKE;
            ST_WAKE:    if (cnt_zero) state_d = ST_RESTART;
            ST_RESTART: state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // Outputs
    always_comb begin
        pin      = 1'b1;
        restart  = 1'b0;
        cnt_load = 1'b0;
        cnt_en   = 1'b0;
        unique case (state_q)
            ST_RUN:     ;
            ST_IDLE: begin
                pin      = keep_pwr;
                cnt_load = wake_req;
            end
            ST_WAKE:    cnt_en  = 1'b1;
            ST_RESTART: restart = 1'b1;
            default:    ;
        endcase
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart); // R9

    AST_STB_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(restart) |-> ($past(state_q) == ST_WAKE)); // R7

    AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAKE || state_q == ST_RESTART) |=> (state_q != ST_IDLE)); // R10

    AST_PIN_DROP_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(pin) |-> (state_q == ST_IDLE)); // R4

    AST_RESTART_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESTART) |=> (state_q == ST_RUN)); // R9

endmodule

// File: rtl/idle_pwr_seq.sv
module idle_pwr_seq #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DLY_W     = idle_pwr_pkg::PWR_DLY_W_DEF,
    parameter int unsigned CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ref_tick,
    input  logic              idle_req,
    input  logic              wake_req,
    output logic              ext_pwr_on,
    output logic              clk_restart
);
    logic             keep_pwr;
    logic [DLY_W-1:0] dly;
    logic             cnt_load;
    logic             cnt_en;
    logic             cnt_zero;

    idle_pwr_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .DLY_W    (DLY_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .keep_pwr(keep_pwr),
        .dly     (dly)
    );

    idle_pwr_delay #(.CNT_W(DLY_W)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .load    (cnt_load),
        .load_val(dly),
        .count_en(cnt_en),
        .tick    (ref_tick),
        .zero    (cnt_zero)
    );

    idle_pwr_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .idle_req(idle_req),
        .wake_req(wake_req),
        .keep_pwr(keep_pwr),
        .cnt_zero(cnt_zero),
        .cnt_load(cnt_load),
        .cnt_en  (cnt_en),
        .pin     (ext_pwr_on),
        .restart (clk_restart)
    );

endmodule

// File: tb/idle_pwr_seq_bench.sv
`timescale 1ns/1ps
module idle_pwr_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ref_tick = 1'b0;
    logic        idle_req = 1'b0;
    logic        wake_req = 1'b0;
    logic        ext_pwr_on;
    logic        clk_restart;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_mode = 0;
    int tick_cnt = 0;
    string cur_req = "R1";

    // Behavioural reference model
    int m_state = 0;
    int m_cnt = 0;
    int m_en = 1;
    int m_dly = 31;

    always #4 clk = ~clk;

    idle_pwr_seq u_idle_pwr_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_tick(ref_tick),
        .idle_req(idle_req), .wake_req(wake_req),
        .ext_pwr_on(ext_pwr_on), .clk_restart(clk_restart)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_state = 0; m_cnt = 0; m_en = 1; m_dly = 31;
        end else begin
            case (m_state)
                0: if (idle_req) m_state = 1;
                1: if (wake_req) begin m_state = 2; m_cnt = m_dly; end
                2: if (m_cnt == 0) m_state = 3;
                   else if (ref_tick) m_cnt = m_cnt - 1;
                default: m_state = 0;
            endcase
            if (reg_wr && reg_addr == 4'd0) begin
                m_en  = int'(reg_wdata[5]);
                m_dly = int'(reg_wdata[4:0]);
            end
        end
    end

    always @(posedge clk) begin
        #2;
        tick_cnt++;
        case (tick_mode)
            1: ref_tick = (tick_cnt % 3 == 0);
            2: ref_tick = 1'b1;
            default: ref_tick = 1'b0;
        endcase
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_req, int'(ext_pwr_on), (m_state != 1 || m_en != 0) ? 1 : 0, "pin");
            chk(cur_req, int'(clk_restart), (m_state == 3) ? 1 : 0, "restart");
            chk(cur_req, int'(reg_rdata),
                (reg_addr == 4'd0) ? (m_en * 32 + m_dly) : 0, "rdata");
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        step(); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(); reg_wr = 1'b0; reg_addr = 4'd0;
    endtask

    task automatic pulse_idle();
        step(); idle_req = 1'b1;
        step(); idle_req = 1'b0;
    endtask

    // Pulse wake and count edges until the strobe is seen
    task automatic wake_and_time(input string req, input int exp_cycles);
        int n = 0;
        step(); wake_req = 1'b1;
        @(posedge clk); #2; wake_req = 1'b0;
        #1;
        while (clk_restart !== 1'b1 && n < 100) begin
            @(posedge clk); #1; n++;
        end
        if (exp_cycles >= 0) chk(req, n + 1, exp_cycles, "wake-to-strobe cycles");
        @(posedge clk); #1;
        chk(req, int'(clk_restart), 0, "strobe width");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2; rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", int'(reg_rdata), 32'h3F, "reset rdata");
        chk("R1", int'(ext_pwr_on), 1, "reset pin");
        chk("R1", int'(clk_restart), 0, "reset strobe");

        // R2 R3: write with reserved bits set, then a write to another address
        cur_req = "R2";
        wr_reg(4'd0, 32'hFFFF_FFC3);
        @(negedge clk);
        chk("R3", int'(reg_rdata), 3, "reserved bits read 0");
        wr_reg(4'd1, 32'h0000_003F);
        step(); reg_addr = 4'd1;
        @(negedge clk);
        chk("R3", int'(reg_rdata), 0, "other address reads 0");
        step(); reg_addr = 4'd0;
        @(negedge clk);
        chk("R2", int'(reg_rdata), 3, "other address write ignored");

        // R10: wake in RUN ignored
        cur_req = "R10";
        step(); wake_req = 1'b1;
        step(); wake_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", int'(ext_pwr_on), 1, "wake in RUN");

        // R4 R6 R7 R9: pin dropped, ticks every cycle, delay 3
        cur_req = "R4";
        tick_mode = 2;
        pulse_idle();
        @(negedge clk);
        chk("R4", int'(ext_pwr_on), 0, "pin low in idle");
        cur_req = "R7";
        wake_and_time("R7", 5);

        // R7 boundary: delay 0
        wr_reg(4'd0, 32'h0000_0000);
        pulse_idle();
        wake_and_time("R7", 2);

        // R5 R8: keep power, sparse ticks, delay 4
        cur_req = "R5";
        tick_mode = 1;
        wr_reg(4'd0, 32'h0000_0024);
        pulse_idle();
        repeat (3) @(negedge clk);
        chk("R5", int'(ext_pwr_on), 1, "pin held high in idle");
        cur_req = "R8";
        wake_and_time("R8", -1);

        // R10: idle held high during wake, en=0
        cur_req = "R10";
        tick_mode = 2;
        wr_reg(4'd0, 32'h0000_0006);
        pulse_idle();
        step(); wake_req = 1'b1;
        step(); wake_req = 1'b0; idle_req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", int'(ext_pwr_on), 1, "idle ignored in wake");
        repeat (10) step();
        idle_req = 1'b0;
        step(); wake_req = 1'b1;
        step(); wake_req = 1'b0;
        repeat (12) step();

        // R11: delay rewritten mid-wake
        cur_req = "R11";
        wr_reg(4'd0, 32'h0000_0008);
        pulse_idle();
        step(); wake_req = 1'b1;
        step(); wake_req = 1'b0;
        wr_reg(4'd0, 32'h0000_001F);
        repeat (20) step();

        // R9: restored to RUN
        cur_req = "R9";
        @(negedge clk);
        chk("R9", int'(ext_pwr_on), 1, "back in RUN");
        chk("R9", int'(clk_restart), 0, "no stray strobe");
        repeat (3) step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule